// File: doc/BRIEF.md
# PWM Fault Trip Override

This block sits between a multi-channel PWM generator and the device pins. It watches a set of external digital fault inputs, each gated by its own enable bit. When any enabled input is seen high after synchronization, a sticky trip flag is latched, a one-cycle interrupt pulse is raised, and every enabled PWM channel has both its true and complementary pins forced to a programmed safe state. That state is high, low or high-impedance. Every pin is presented as a data bit plus an output-enable bit.

The safe levels are global. One bit sets the level of all true outputs and another sets the level of all complementary outputs. A third bit makes the tripped pins high-impedance instead of driven. The override holds until software writes zero to the trip flag through a small register write port. Later glitches on the fault lines can neither clear a trip nor start a new one while the flag is still set. Software therefore gets a chance to inspect the driven load before the outputs are released.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset the trip flag, the interrupt and all configuration bits are 0, and each pin passes its PWM input through with output-enable 1.
- R2: A fault input that is enabled and held high sets the trip flag on the third rising clock edge after it rises, because the input passes two synchronizer flops and then the flag flop.
- R3: A fault input whose enable bit is 0 never sets the trip flag.
- R4: With several inputs enabled, any one of them going high causes a trip.
- R5: The interrupt output is high for exactly the one cycle in which the trip flag goes from 0 to 1.
- R6: Once set, the trip flag stays set when the fault inputs return low, including after a fault pulse only one clock long.
- R7: A write of 0 to bit 0 at address 1 clears the trip flag on that edge. If an enabled fault is still high after synchronization, the flag is set again on the following edge.
- R8: A write of 1 to bit 0 at address 1 leaves the trip flag unchanged.
- R9: While tripped, each enabled channel drives its true pin to the true-level bit and its complementary pin to the complementary-level bit, with output-enable 1.
- R10: While tripped with the tri-state bit set, both pins of each enabled channel have output-enable 0, and their data still carry the programmed levels.
- R11: Channels whose channel-enable input is 0 pass their PWM inputs through unchanged with output-enable 1, even while tripped.
- R12: A write to address 0 loads the configuration on that edge: bits [3:0] are the fault enables (bit n for fault input n), bit 4 is the true level, bit 5 is the complementary level and bit 6 is tri-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultIn | input | 4 | Raw external fault inputs, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 trip status |
| regWrData | input | 8 | Register write data |
| chanEn | input | 4 | Per-channel enable from the PWM generator |
| pwmTrue | input | 4 | True PWM waveforms |
| pwmComp | input | 4 | Complementary PWM waveforms |
| pinData | output | 4 | True pin data |
| pinDataN | output | 4 | Complementary pin data |
| pinOe | output | 4 | True pin output-enable |
| pinOeN | output | 4 | Complementary pin output-enable |
| tripFlag | output | 1 | Trip-detected flag |
| tripIrq | output | 1 | One-cycle interrupt pulse on trip |

## Verification
The bench counts edges from a fault rising to the flag setting. A design with one synchronizer stage too few or too many sets the flag a cycle early or late. It clears the flag while a fault is still high, and expects the flag back one edge later with a second interrupt pulse. A design that gives set priority over clear would never show the gap, and one that only reacts to fault edges would stay clear. A single-cycle fault pulse must still latch and stay latched. A write of 1 must neither set nor clear the flag. The override table mixes enabled and disabled channels under every level and tri-state combination, which catches swapped polarity groups, an override that ignores the channel enable, and a tri-state that drops the data levels.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic overrideOn;
    logic levelTrue;
    logic levelComp;
    logic triState;
  } tripCtrl_t;

  localparam logic ADDR_CFG    = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               anyFault,
  output logic [NUM_SRC-1:0] srcEn,
  output tripCtrl_t          ctrl,
  output logic               tripFlag,
  output logic               tripIrq
);
  localparam int LVT_BIT = NUM_SRC;
  localparam int LVC_BIT = NUM_SRC + 1;
  localparam int TRI_BIT = NUM_SRC + 2;

  logic levelTrueQ, levelCompQ, triStateQ;
  logic cfgWr, clearWr;

  assign cfgWr   = regWrEn && (regAddr == ADDR_CFG);
  assign clearWr = regWrEn && (regAddr == ADDR_STATUS) && !regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcEn      <= '0;
      levelTrueQ <= 1'b0;
      levelCompQ <= 1'b0;
      triStateQ  <= 1'b0;
    end else if (cfgWr) begin
      srcEn      <= regWrData[NUM_SRC-1:0];
      levelTrueQ <= regWrData[LVT_BIT];
      levelCompQ <= regWrData[LVC_BIT];
      triStateQ  <= regWrData[TRI_BIT];
    end
  end

  // clear wins on its own edge; a live fault re-sets on the next one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripFlag <= 1'b0;
      tripIrq  <= 1'b0;
    end else begin
      tripIrq <= anyFault && !clearWr && !tripFlag;
      if (clearWr)       tripFlag <= 1'b0;
      else if (anyFault) tripFlag <= 1'b1;
    end
  end

  assign ctrl.overrideOn = tripFlag;
  assign ctrl.levelTrue  = levelTrueQ;
  assign ctrl.levelComp  = levelCompQ;
  assign ctrl.triState   = triStateQ;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    tripFlag && !clearWr |=> tripFlag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearWr |=> !tripFlag);
  a_r8_write_one: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_STATUS && regWrData[0] && !tripFlag && !anyFault
    |=> !tripFlag);
  a_r2_set: assert property (@(posedge clk) disable iff (!rstN)
    anyFault && !clearWr |=> tripFlag);
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    tripIrq |-> tripFlag && !$past(tripFlag));
endmodule

// File: rtl/pwm_trip_datapath.sv
module pwm_trip_datapath
  import pwm_trip_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  tripCtrl_t          ctrl,
  input  logic [NUM_CH-1:0]  chanEn,
  input  logic [NUM_CH-1:0]  pwmTrue,
  input  logic [NUM_CH-1:0]  pwmComp,
  output logic               anyFault,
  output logic [NUM_CH-1:0]  pinData,
  output logic [NUM_CH-1:0]  pinDataN,
  output logic [NUM_CH-1:0]  pinOe,
  output logic [NUM_CH-1:0]  pinOeN
);
  logic [NUM_SRC-1:0] faultSync;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pwm_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .dIn (faultIn[s]),
      .dOut(faultSync[s])
    );
  end

  assign anyFault = |(faultSync & srcEn);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic forceCh;
    assign forceCh = ctrl.overrideOn && chanEn[c];

    always_comb begin
      if (forceCh) begin
        pinData[c]  = ctrl.levelTrue;
        pinDataN[c] = ctrl.levelComp;
        pinOe[c]    = !ctrl.triState;
        pinOeN[c]   = !ctrl.triState;
      end else begin
        pinData[c]  = pwmTrue[c];
        pinDataN[c] = pwmComp[c];
        pinOe[c]    = 1'b1;
        pinOeN[c]   = 1'b1;
      end
    end

    a_r11_pass: assert property (@(posedge clk) disable iff (!rstN)
      !chanEn[c] |-> pinData[c] == pwmTrue[c] && pinDataN[c] == pwmComp[c] && pinOe[c]);
    a_r10_tri: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.overrideOn && ctrl.triState && chanEn[c] |-> !pinOe[c] && !pinOeN[c]);
  end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import pwm_trip_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_CH-1:0]  chanEn,
  input  logic [NUM_CH-1:0]  pwmTrue,
  input  logic [NUM_CH-1:0]  pwmComp,
  output logic [NUM_CH-1:0]  pinData,
  output logic [NUM_CH-1:0]  pinDataN,
  output logic [NUM_CH-1:0]  pinOe,
  output logic [NUM_CH-1:0]  pinOeN,
  output logic               tripFlag,
  output logic               tripIrq
);
  tripCtrl_t          ctrl;
  logic [NUM_SRC-1:0] srcEn;
  logic               anyFault;

  pwm_trip_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .anyFault (anyFault),
    .srcEn    (srcEn),
    .ctrl     (ctrl),
    .tripFlag (tripFlag),
    .tripIrq  (tripIrq)
  );

  pwm_trip_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .faultIn (faultIn),
    .srcEn   (srcEn),
    .ctrl    (ctrl),
    .chanEn  (chanEn),
    .pwmTrue (pwmTrue),
    .pwmComp (pwmComp),
    .anyFault(anyFault),
    .pinData (pinData),
    .pinDataN(pinDataN),
    .pinOe   (pinOe),
    .pinOeN  (pinOeN)
  );

  a_r9_forced_level: assert property (@(posedge clk) disable iff (!rstN)
    tripFlag && !ctrl.triState && chanEn[0] |-> pinOe[0] && pinData[0] == ctrl.levelTrue);
endmodule

// File: tb/pwm_trip_guard_bench.sv
`timescale 1ns/1ps
module pwm_trip_guard_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] faultIn = '0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [3:0] chanEn = '0, pwmTrue = '0, pwmComp = '0;
  logic [3:0] pinData, pinDataN, pinOe, pinOeN;
  logic       tripFlag, tripIrq;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  pwm_trip_guard u_pwm_trip_guard (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .chanEn(chanEn),
    .pwmTrue(pwmTrue), .pwmComp(pwmComp), .pinData(pinData),
    .pinDataN(pinDataN), .pinOe(pinOe), .pinOeN(pinOeN),
    .tripFlag(tripFlag), .tripIrq(tripIrq)
  );

  // cfg = {tri, levelComp, levelTrue}
  typedef struct packed {
    logic [2:0] cfg;
    logic [3:0] en, pt, pc, d, dn, oe;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{3'b000, 4'b1111, 4'b1010, 4'b0101, 4'b0000, 4'b0000, 4'b1111},
    '{3'b001, 4'b1111, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 4'b1111},
    '{3'b010, 4'b0011, 4'b1100, 4'b0110, 4'b1100, 4'b0111, 4'b1111},
    '{3'b100, 4'b0101, 4'b1111, 4'b0000, 4'b1010, 4'b0000, 4'b1010},
    '{3'b011, 4'b1001, 4'b0110, 4'b1001, 4'b1111, 4'b1001, 4'b1111},
    '{3'b111, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    chanEn = 4'b1111; pwmTrue = 4'b0110; pwmComp = 4'b1001;
    tick(); tick();
    // R1: reset state, pass-through
    check("R1 flag", tripFlag, 0);
    check("R1 irq", tripIrq, 0);
    check("R1 data", {pinData, pinDataN}, 8'h69);
    check("R1 oe", {pinOe, pinOeN}, 8'hFF);
    rstN = 1'b1;
    tick();
    // R1/R12: config 0 means fault ignored
    faultIn = 4'b1111;
    tick(); tick(); tick(); tick();
    check("R1 cfg zero ignores fault", tripFlag, 0);
    faultIn = '0; tick(); tick(); tick();

    // R3: disabled sources
    wr(1'b0, 8'h01);  // R12: enable source 0 only
    faultIn = 4'b1110;
    repeat (5) tick();
    check("R3 disabled sources", tripFlag, 0);
    faultIn = 4'b0000; tick(); tick();

    // R2 timing and R5 pulse
    faultIn = 4'b0001;
    tick(); tick();
    check("R2 not yet after two edges", tripFlag, 0);
    tick();
    check("R2 set on third edge", tripFlag, 1);
    check("R5 irq pulse", tripIrq, 1);
    tick();
    check("R5 irq one cycle", tripIrq, 0);

    // R7: clear while fault still high
    wr(1'b1, 8'h00);
    check("R7 cleared on write", tripFlag, 0);
    tick();
    check("R7 re-set with live fault", tripFlag, 1);
    check("R5 irq on re-set", tripIrq, 1);

    // R6: sticky after fault drops
    faultIn = '0;
    repeat (4) tick();
    check("R6 sticky", tripFlag, 1);

    // R7: clear with fault gone
    wr(1'b1, 8'hFE);
    check("R7 clear", tripFlag, 0);
    tick();
    check("R7 stays clear", tripFlag, 0);

    // R8: writing 1 has no effect (from clear)
    wr(1'b1, 8'h01);
    tick();
    check("R8 write one no set", tripFlag, 0);

    // R6: one-cycle pulse latches
    faultIn = 4'b0001; tick(); faultIn = '0;
    tick(); tick();
    check("R6 short pulse latched", tripFlag, 1);
    repeat (3) tick();
    check("R6 short pulse sticky", tripFlag, 1);

    // R8: writing 1 has no effect (from set)
    wr(1'b1, 8'h01);
    check("R8 write one no clear", tripFlag, 1);
    wr(1'b1, 8'h00);
    tick();

    // R4: multiple enables, one source trips
    wr(1'b0, 8'h0A);
    faultIn = 4'b1000;
    tick(); tick(); tick();
    check("R4 any enabled source", tripFlag, 1);
    faultIn = '0;

    // R9 R10 R11 R12: override table, tripped state held
    for (int i = 0; i < 6; i++) begin
      wr(1'b0, {1'b0, VEC[i].cfg, 4'b1010});
      chanEn = VEC[i].en; pwmTrue = VEC[i].pt; pwmComp = VEC[i].pc;
      #1;
      check("R9/R11 true data", pinData, VEC[i].d);
      check("R9/R11 comp data", pinDataN, VEC[i].dn);
      check("R10 true oe", pinOe, VEC[i].oe);
      check("R10 comp oe", pinOeN, VEC[i].oe);
    end

    // R11: release returns all to pass-through
    wr(1'b1, 8'h00);
    chanEn = 4'b1111; pwmTrue = 4'b0011; pwmComp = 4'b1100; #1;
    check("R11 released pass data", {pinData, pinDataN}, 8'h3C);
    check("R11 released oe", {pinOe, pinOeN}, 8'hFF);
    finishRun();
  end
endmodule